// File: doc/BRIEF.md
# Set/Clear Pin-Control Register Bank

This block is a small bank of byte-wide control registers behind a narrow register window. Software selects a register with address bits 4..2. For most registers, address bit 1 chooses the write style. A write either ORs the data into the register or clears exactly the bits that are set in the data. As a result, independent drivers can change single bits without a read-modify-write. The PWM match register is the exception: it takes a plain load.

The registers drive:
- active-high reset lines for four peripherals;
- multiplexer selects for a serial port, the PWM outputs and an audio PCM path;
- an 8-bit hibernate/wake control byte;
- the direction and level of five general-purpose pins, plus an option to route one of those pins onto an interrupt line;
- an 8-bit output port built from spare address pins.

Several registers return different content on read than what was written. The control register returns the logic version. The feature register returns a board strap and the PCB revision. The direction register returns the live pin levels, and the TTL port returns its input pins. Both live-level paths go through a two-flop synchronizer.

Top module: `pinctl_regbank`

## Requirements
- R1: Address bits 4..2 select the register: 0 control, 1 feature, 2 hibernate, 3 PWM, 4 pin direction, 5 pin level, 6 TTL port. A write is accepted only when `bus_wr` is high. A write to select value 7, or a cycle without `bus_wr`, leaves every register unchanged.
- R2: For every register except PWM, a write with address bit 1 = 0 sets each register bit whose data bit is 1 and leaves the other bits unchanged.
- R3: For every register except PWM, a write with address bit 1 = 1 clears each register bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A PWM write ignores address bit 1 and data bit 7 and loads data bits 6..0 into `pwm_match` directly.
- R5: Control bits 2, 3, 4 and 5 drive `rst_codec`, `rst_phy`, `rst_wlan` and `rst_bt` (active high). Reading the control register returns the `VERSION` parameter (default 8'h07).
- R6: Feature bits drive the outputs as follows:
  - bit 0: `uart_to_edge`
  - bit 1: `uart_to_bt`
  - bit 2: `uart_off`
  - bit 3: `ttl_en`
  - bits 6..4: `pwm_pin_en[2:0]`
  - bit 7: `pcm_route`
- R7: Reading the feature register returns `{pcb_rev, 3'b000, strap_narrow}`.
- R8: Direction bits 4..0 drive `gpio_oe` (1 = output), and pin-level bits 4..0 drive `gpio_out`. Direction bit 5 sets `irq_oe`, which makes `irq_out` follow `gpio_in[3]` without delay. While direction bit 5 is clear, `irq_out` is 0.
- R9: Reading the direction register returns the `gpio_in` levels, zero-extended. They pass through two flops, so a change on `gpio_in` is visible on a read after the second rising edge, not after the first.
- R10: With `ttl_en` set, `ttl_oe` is 1 and `ttl_out` carries the TTL register. A TTL read then returns `ttl_in` through two flops. With `ttl_en` clear, `ttl_oe` is 0 and a TTL read returns 0.
- R11: Reads of the hibernate, PWM, pin-level and unused (7) registers return 0. The hibernate register drives `hib_ctrl`.
- R12: Reset (`rst_n` low) clears every register and synchronizer. This leaves every pin an input, every reset line and route inactive, and `pwm_match` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Address bits 4..1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| strap_narrow | input | 1 | Address-mode strap |
| pcb_rev | input | 4 | Board revision |
| rst_codec | output | 1 | Audio codec reset |
| rst_phy | output | 1 | Ethernet PHY reset |
| rst_wlan | output | 1 | WLAN reset |
| rst_bt | output | 1 | BT reset |
| uart_to_edge | output | 1 | Serial port to edge connector |
| uart_to_bt | output | 1 | Serial port to BT |
| uart_off | output | 1 | Serial port disabled |
| ttl_en | output | 1 | TTL port enabled |
| pwm_pin_en | output | 3 | PWM output enable per pin |
| pcm_route | output | 1 | BT PCM routed out |
| hib_ctrl | output | 8 | Hibernate/wake control byte |
| pwm_match | output | 7 | PWM match value |
| gpio_in | input | 5 | Pin levels |
| gpio_oe | output | 5 | Pin output enables |
| gpio_out | output | 5 | Pin drive levels |
| irq_oe | output | 1 | Interrupt line driven by routed pin |
| irq_out | output | 1 | Routed pin level |
| ttl_in | input | 8 | Lower address pins as inputs |
| ttl_oe | output | 1 | Upper address pins driven |
| ttl_out | output | 8 | Upper address pin levels |

## Verification
The assertions check three things on every cycle:
- the per-register write rules: set bits end up 1, cleared bits end up 0, an unwritten register holds its value, and PWM takes a direct load;
- the read rules for the version and for a disabled TTL port;
- that the interrupt line is quiet while not routed.

Only the bench scenarios can show the bit-to-pin mapping of each register, the exact two-edge latency of the synchronized level reads, and the strap and revision read-back. They are also needed to show that a write to the unused select value has no effect on any output, and that a mid-run reset returns everything to zero.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_FEAT = 3'd1,
    SEL_HIB  = 3'd2,
    SEL_PWM  = 3'd3,
    SEL_DIR  = 3'd4,
    SEL_LVL  = 3'd5,
    SEL_TTL  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Next value of a set/clear register: OR in or strip out the masked bits.
  function automatic logic [REG_W-1:0] setclr_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] mask,
                                                   input logic clr);
    return clr ? (cur & ~mask) : (cur | mask);
  endfunction
endpackage

// File: rtl/pinctl_bitreg.sv
module pinctl_bitreg #(
  parameter int  W         = 8,
  parameter bit  LOAD_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         clr,
  input  logic [7:0]   d,
  output logic [W-1:0] q
);
  import pinctl_pkg::*;

  logic [W-1:0] nxt;

  generate
    if (LOAD_MODE) begin : g_load
      assign nxt = d[W-1:0];
      logic unused_ld;
      assign unused_ld = clr;
    end else begin : g_setclr
      logic [REG_W-1:0] wide;
      assign wide = setclr_next(REG_W'(q), d, clr);
      assign nxt  = wide[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(we)) |-> q == $past(q));

  generate
    if (LOAD_MODE) begin : g_chk_load
      assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |-> q == $past(d[W-1:0]));
    end else begin : g_chk_setclr
      assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && !$past(clr)) |->
          ((q & $past(d[W-1:0])) == $past(d[W-1:0])));
      assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && $past(clr)) |->
          ((q & $past(d[W-1:0])) == '0));
      assert_others_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |->
          ((q & ~$past(d[W-1:0])) == ($past(q) & ~$past(d[W-1:0]))));
    end
  endgenerate
endmodule

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= (s == 0) ? din : stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

  assert_first_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stg[0] == $past(din));
endmodule

// File: rtl/pinctl_rdmux.sv
module pinctl_rdmux #(
  parameter logic [7:0] VERSION = 8'h07,
  parameter int         NGPIO   = 5,
  parameter int         TTL_W   = 8
) (
  input  pinctl_pkg::reg_sel_e sel,
  input  logic                 strap_narrow,
  input  logic [3:0]           pcb_rev,
  input  logic [NGPIO-1:0]     pin_lvl,
  input  logic                 ttl_en,
  input  logic [TTL_W-1:0]     ttl_lvl,
  output logic [7:0]           rdata
);
  import pinctl_pkg::*;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: rdata = VERSION;
      SEL_FEAT: rdata = {pcb_rev, 3'b000, strap_narrow};
      SEL_DIR:  rdata[NGPIO-1:0] = pin_lvl;
      SEL_TTL:  if (ttl_en) rdata[TTL_W-1:0] = ttl_lvl;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinctl_regbank.sv
module pinctl_regbank #(
  parameter logic [7:0] VERSION     = 8'h07,
  parameter int         NGPIO       = 5,
  parameter int         IRQ_PIN     = 3,
  parameter int         TTL_W       = 8,
  parameter int         PWM_W       = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [4:1]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             strap_narrow,
  input  logic [3:0]       pcb_rev,
  output logic             rst_codec,
  output logic             rst_phy,
  output logic             rst_wlan,
  output logic             rst_bt,
  output logic             uart_to_edge,
  output logic             uart_to_bt,
  output logic             uart_off,
  output logic             ttl_en,
  output logic [2:0]       pwm_pin_en,
  output logic             pcm_route,
  output logic [7:0]       hib_ctrl,
  output logic [PWM_W-1:0] pwm_match,
  input  logic [NGPIO-1:0] gpio_in,
  output logic [NGPIO-1:0] gpio_oe,
  output logic [NGPIO-1:0] gpio_out,
  output logic             irq_oe,
  output logic             irq_out,
  input  logic [TTL_W-1:0] ttl_in,
  output logic             ttl_oe,
  output logic [TTL_W-1:0] ttl_out
);
  import pinctl_pkg::*;

  localparam int NSEL = 8;

  reg_sel_e   sel;
  logic       clr_mode;
  logic [NSEL-1:0] wr_hit;
  logic [7:0] bank [NSEL];

  assign sel      = reg_sel_e'(bus_addr[4:2]);
  assign clr_mode = bus_addr[1];

  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_reg
      assign wr_hit[g] = bus_wr && (bus_addr[4:2] == 3'(g));
      if (g == int'(SEL_PWM)) begin : g_pwm
        logic [PWM_W-1:0] q;
        pinctl_bitreg #(.W(PWM_W), .LOAD_MODE(1'b1)) u_reg (
          .clk(clk), .rst_n(rst_n), .we(wr_hit[g]), .clr(clr_mode),
          .d(bus_wdata), .q(q));
        assign bank[g] = 8'(q);
      end else if (g == int'(SEL_NONE)) begin : g_hole
        assign bank[g] = '0;
      end else begin : g_sc
        logic [REG_W-1:0] q;
        pinctl_bitreg #(.W(REG_W), .LOAD_MODE(1'b0)) u_reg (
          .clk(clk), .rst_n(rst_n), .we(wr_hit[g]), .clr(clr_mode),
          .d(bus_wdata), .q(q));
        assign bank[g] = q;
      end
    end
  endgenerate

  // Control register: peripheral reset lines
  logic [7:0] ctrl_q, feat_q, dir_q, lvl_q;
  assign ctrl_q    = bank[SEL_CTRL];
  assign feat_q    = bank[SEL_FEAT];
  assign dir_q     = bank[SEL_DIR];
  assign lvl_q     = bank[SEL_LVL];
  assign rst_codec = ctrl_q[2];
  assign rst_phy   = ctrl_q[3];
  assign rst_wlan  = ctrl_q[4];
  assign rst_bt    = ctrl_q[5];

  // Feature register: routing selects
  assign uart_to_edge = feat_q[0];
  assign uart_to_bt   = feat_q[1];
  assign uart_off     = feat_q[2];
  assign ttl_en       = feat_q[3];
  assign pwm_pin_en   = feat_q[6:4];
  assign pcm_route    = feat_q[7];

  assign hib_ctrl  = bank[SEL_HIB];
  assign pwm_match = bank[SEL_PWM][PWM_W-1:0];

  // GPIO pins and interrupt routing
  assign gpio_oe  = dir_q[NGPIO-1:0];
  assign gpio_out = lvl_q[NGPIO-1:0];
  assign irq_oe   = dir_q[NGPIO];
  assign irq_out  = irq_oe & gpio_in[IRQ_PIN];

  // TTL port on spare address pins
  assign ttl_oe  = ttl_en;
  assign ttl_out = bank[SEL_TTL][TTL_W-1:0];

  // Synchronized live levels
  logic [NGPIO-1:0] pin_lvl_s;
  logic [TTL_W-1:0] ttl_lvl_s;

  pinctl_sync #(.W(NGPIO), .STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .din(gpio_in), .dout(pin_lvl_s));
  pinctl_sync #(.W(TTL_W), .STAGES(SYNC_STAGES)) u_sync_ttl (
    .clk(clk), .rst_n(rst_n), .din(ttl_in), .dout(ttl_lvl_s));

  pinctl_rdmux #(.VERSION(VERSION), .NGPIO(NGPIO), .TTL_W(TTL_W)) u_rdmux (
    .sel(sel), .strap_narrow(strap_narrow), .pcb_rev(pcb_rev),
    .pin_lvl(pin_lvl_s), .ttl_en(ttl_en), .ttl_lvl(ttl_lvl_s),
    .rdata(bus_rdata));

  logic unused_bits;
  assign unused_bits = ^{ctrl_q[7:6], ctrl_q[1:0], dir_q[7:NGPIO+1], lvl_q[7:NGPIO],
                         bank[SEL_NONE]};

  assert_version_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[4:2] == 3'(SEL_CTRL)) |-> bus_rdata == VERSION);
  assert_ttl_read_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[4:2] == 3'(SEL_TTL) && !ttl_en) |-> bus_rdata == 8'h00);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe |-> !irq_out);
  assert_zero_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[4:2] == 3'(SEL_HIB) || bus_addr[4:2] == 3'(SEL_PWM) ||
     bus_addr[4:2] == 3'(SEL_LVL) || bus_addr[4:2] == 3'(SEL_NONE)) |-> bus_rdata == 8'h00);
endmodule

// File: tb/pinctl_regbank_tb.sv
module pinctl_regbank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:1] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       strap_narrow = 1'b0;
  logic [3:0] pcb_rev = '0;
  logic rst_codec, rst_phy, rst_wlan, rst_bt;
  logic uart_to_edge, uart_to_bt, uart_off, ttl_en, pcm_route;
  logic [2:0] pwm_pin_en;
  logic [7:0] hib_ctrl;
  logic [6:0] pwm_match;
  logic [4:0] gpio_in = '0;
  logic [4:0] gpio_oe, gpio_out;
  logic irq_oe, irq_out, ttl_oe;
  logic [7:0] ttl_in = '0;
  logic [7:0] ttl_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pinctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_narrow(strap_narrow),
    .pcb_rev(pcb_rev), .rst_codec(rst_codec), .rst_phy(rst_phy),
    .rst_wlan(rst_wlan), .rst_bt(rst_bt), .uart_to_edge(uart_to_edge),
    .uart_to_bt(uart_to_bt), .uart_off(uart_off), .ttl_en(ttl_en),
    .pwm_pin_en(pwm_pin_en), .pcm_route(pcm_route), .hib_ctrl(hib_ctrl),
    .pwm_match(pwm_match), .gpio_in(gpio_in), .gpio_oe(gpio_oe),
    .gpio_out(gpio_out), .irq_oe(irq_oe), .irq_out(irq_out),
    .ttl_in(ttl_in), .ttl_oe(ttl_oe), .ttl_out(ttl_out));

  // vector: [22:20] select, [19] clear, [18:11] data, [10:8] view, [7:0] expected view
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'h3C, 3'd0, 8'h0F},  // R2 R5 resets set
    {3'd0, 1'b1, 8'h08, 3'd0, 8'h0D},  // R3 clear phy only
    {3'd0, 1'b0, 8'h03, 3'd0, 8'h0D},  // R5 unused control bits
    {3'd1, 1'b0, 8'h81, 3'd1, 8'h81},  // R6 feature set
    {3'd1, 1'b1, 8'h01, 3'd1, 8'h80},  // R6 R3 feature clear
    {3'd2, 1'b0, 8'h25, 3'd2, 8'h25},  // R11 hibernate set
    {3'd2, 1'b1, 8'h04, 3'd2, 8'h21},  // R3 hibernate clear
    {3'd3, 1'b1, 8'hFF, 3'd3, 8'h7F},  // R4 clr bit ignored, bit7 dropped
    {3'd3, 1'b0, 8'h05, 3'd3, 8'h05},  // R4 direct load, not OR
    {3'd4, 1'b0, 8'h15, 3'd4, 8'h15},  // R8 direction
    {3'd5, 1'b0, 8'h1F, 3'd5, 8'h1F},  // R8 levels
    {3'd5, 1'b1, 8'h0A, 3'd5, 8'h15},  // R3 level clear
    {3'd7, 1'b0, 8'hFF, 3'd3, 8'h05},  // R1 unused select: pwm untouched
    {3'd6, 1'b0, 8'hA5, 3'd6, 8'hA5},  // R10 ttl register
    {3'd6, 1'b1, 8'h0F, 3'd6, 8'hA0},  // R3 ttl clear
    {3'd4, 1'b0, 8'h20, 3'd7, 8'h35}   // R8 irq route bit
  };

  function automatic logic [7:0] view(input logic [2:0] v);
    case (v)
      3'd0: return {4'b0, rst_bt, rst_wlan, rst_phy, rst_codec};
      3'd1: return {pcm_route, pwm_pin_en, ttl_en, uart_off, uart_to_bt, uart_to_edge};
      3'd2: return hib_ctrl;
      3'd3: return {1'b0, pwm_match};
      3'd4: return {3'b0, gpio_oe};
      3'd5: return {3'b0, gpio_out};
      3'd6: return ttl_out;
      default: return {2'b0, irq_oe, gpio_oe};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic c, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {s, c}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    bus_addr = {s, 1'b0};
    #1 d = bus_rdata;
  endtask

  task automatic all_zero(input string req);
    check(req, view(3'd0), 8'h00);
    check(req, view(3'd1), 8'h00);
    check(req, hib_ctrl | {1'b0, pwm_match} | ttl_out, 8'h00);
    check(req, {irq_oe, ttl_oe, gpio_oe, 1'b0}, 8'h00);
    check(req, {3'b0, gpio_out}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    all_zero("R12 reset");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][22:20], VEC[i][19], VEC[i][18:11]);
      check($sformatf("R1-vec%0d", i), view(VEC[i][10:8]), VEC[i][7:0]);
    end

    rd(3'd0, r); check("R5 version read", r, 8'h07);
    strap_narrow = 1'b1; pcb_rev = 4'hA;
    rd(3'd1, r); check("R7 feature read", r, 8'hA1);
    rd(3'd2, r); check("R11 hib read", r, 8'h00);
    rd(3'd3, r); check("R11 pwm read", r, 8'h00);
    rd(3'd5, r); check("R11 level read", r, 8'h00);
    rd(3'd7, r); check("R11 unused read", r, 8'h00);

    // R9 two-edge latency of pin levels
    rd(3'd4, r);
    @(negedge clk); gpio_in = 5'h0A;
    @(negedge clk); rd(3'd4, r); check("R9 one edge", r, 8'h00);
    @(negedge clk); rd(3'd4, r); check("R9 two edges", r, 8'h0A);

    // R8 interrupt follows pin 3 at once
    #1 check("R8 irq high", {7'b0, irq_out}, 8'h01);
    gpio_in = 5'h02;
    #1 check("R8 irq low", {7'b0, irq_out}, 8'h00);

    // R10 TTL port disabled then enabled
    ttl_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(3'd6, r); check("R10 ttl off read", r, 8'h00);
    check("R10 ttl off oe", {7'b0, ttl_oe}, 8'h00);
    wr(3'd1, 1'b0, 8'h08);
    rd(3'd6, r); check("R10 ttl on read", r, 8'h3C);
    check("R10 ttl on oe", {7'b0, ttl_oe}, 8'h01);
    check("R10 ttl out", ttl_out, 8'hA0);
    wr(3'd1, 1'b1, 8'h08);
    check("R10 ttl disabled oe", {7'b0, ttl_oe}, 8'h00);

    // R1 no write strobe: data and address alone change nothing
    @(negedge clk); bus_addr = {3'd2, 1'b0}; bus_wdata = 8'hFF;
    @(negedge clk); check("R1 no strobe", hib_ctrl, 8'h21);

    // R12 mid-run reset
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    all_zero("R12 mid reset");
    rd(3'd4, r); check("R12 sync cleared", r, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule